// File: doc/BRIEF.md
# Banked Configuration Register Space

This block is the configuration front end of a multi-function peripheral chip. A host reaches a byte-wide register space through two ports. Offset 0 holds a register index and offset 1 carries the data for the register that index names. Some registers are global: a chip identifier, a revision code and a device selector. The other registers belong to one of fifteen logical devices, and only the bank of the device named by the selector is visible. Each device bank holds an enable flag and a 16-bit I/O base address. The enable flags and base addresses of all devices drive the rest of the chip continuously.

When the selector names the general-purpose I/O device (number 7), three more registers appear. The first selects one of 29 pins by port and bit. The second and third reach the drive configuration and the event configuration of the selected pin. The drive configuration of every pin goes straight out to the pin logic.

The bus is a synchronous byte strobe interface. A write takes effect on the clock edge that samples it. A read returns its data on `rdData` after the edge that samples `busRd`, and `rdData` holds that value until the next read.

Top module: `cfg_space_top`

## Requirements
- R1: A write at offset 0 stores the index. A read at offset 0 returns the stored index. Any read appears on `rdData` one clock edge after the edge that samples it.
- R2: Index 0x20 reads 0xE9 and index 0x27 reads the revision parameter (0x01 by default). Writes to either index change nothing.
- R3: Index 0x07 holds the selected device number. Values 0x00 to 0x0E are accepted, and writes above 0x0E leave the previous number in place.
- R4: Index 0x30 sets bit 0 of the selected device's enable flag, and the flag drives `devEnable[n]`. Bits 7:1 read as 0.
- R5: Indices 0x60 and 0x61 hold bits 15:8 and 7:0 of the selected device's base address, which drives `devBase[16*n+15:16*n]`.
- R6: Writes to the bank registers change only the device that is selected at that moment.
- R7: Index 0xF0 is the pin selector (port in bits 7:4, bit within port in bits 2:0, read back with bit 3 as 0, pin = port*8+bit). It exists only while device 7 is selected. In any other bank, indices 0xF0 to 0xF2 read 0 and ignore writes.
- R8: Index 0xF1 reaches the selected pin's drive configuration: bit 0 output enable, bit 1 push-pull (0 means open-drain), bit 2 pull-up. These bits drive `pinOutEn`, `pinPushPull` and `pinPullUp` at the pin's position.
- R9: Index 0xF2 reaches the selected pin's two event bits, which drive `pinEvtCfg[2*p+1:2*p]`.
- R10: When the pin selector names a pin above 28, indices 0xF1 and 0xF2 read 0 and ignore writes. Pin 28 is valid.
- R11: Unimplemented indices read 0x00 and ignore writes.
- R12: Reset clears the index, the device number, all enable flags, base addresses, pin selector, pin configurations and `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 1 | Port offset: 0 index, 1 data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| devEnable | output | 15 | Enable flag per logical device |
| devBase | output | 240 | 16-bit base address per logical device |
| pinOutEn | output | 29 | Output enable per pin |
| pinPushPull | output | 29 | Push-pull select per pin |
| pinPullUp | output | 29 | Pull-up enable per pin |
| pinEvtCfg | output | 58 | Two event bits per pin |

## Verification
The assertions assume a host that raises at most one strobe in a cycle and keeps `busAddr` and `busWdata` steady while the strobe is high. The bench drives each strobe for exactly one cycle, on the falling edge, and never raises read and write together. The hold properties also assume that no register changes outside a write strobe. They rely on the device number staying within range, and the bench probes that directly with an out-of-range write.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  typedef enum logic [3:0] {
    KIND_NONE,
    KIND_CHIPID,
    KIND_REV,
    KIND_DEVSEL,
    KIND_ENABLE,
    KIND_BASEHI,
    KIND_BASELO,
    KIND_PINSEL,
    KIND_PINCFG,
    KIND_PINEVT
  } regKind_e;

  typedef struct packed {
    logic       wrData;
    logic       rdData;
    logic       rdIndex;
    regKind_e   kind;
    logic [7:0] index;
  } cfgStrobe_t;

  localparam logic [7:0] IDX_DEVSEL = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;
  localparam logic [7:0] IDX_REV    = 8'h27;
  localparam logic [7:0] IDX_ENABLE = 8'h30;
  localparam logic [7:0] IDX_BASEHI = 8'h60;
  localparam logic [7:0] IDX_BASELO = 8'h61;
  localparam logic [7:0] IDX_PINSEL = 8'hF0;
  localparam logic [7:0] IDX_PINCFG = 8'hF1;
  localparam logic [7:0] IDX_PINEVT = 8'hF2;

endpackage

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  input  logic       gpioBankSel,
  output cfgStrobe_t strobes
);

  logic [7:0] indexReg;
  regKind_e   kindNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) indexReg <= 8'h00;
    else if (busWr && !busAddr) indexReg <= busWdata;
  end

  always_comb begin
    kindNow = KIND_NONE;
    case (indexReg)
      IDX_DEVSEL: kindNow = KIND_DEVSEL;
      IDX_CHIPID: kindNow = KIND_CHIPID;
      IDX_REV:    kindNow = KIND_REV;
      IDX_ENABLE: kindNow = KIND_ENABLE;
      IDX_BASEHI: kindNow = KIND_BASEHI;
      IDX_BASELO: kindNow = KIND_BASELO;
      IDX_PINSEL: kindNow = gpioBankSel ? KIND_PINSEL : KIND_NONE;
      IDX_PINCFG: kindNow = gpioBankSel ? KIND_PINCFG : KIND_NONE;
      IDX_PINEVT: kindNow = gpioBankSel ? KIND_PINEVT : KIND_NONE;
      default:    kindNow = KIND_NONE;
    endcase
  end

  always_comb begin
    strobes.wrData  = busWr && busAddr;
    strobes.rdData  = busRd && busAddr;
    strobes.rdIndex = busRd && !busAddr;
    strobes.kind    = kindNow;
    strobes.index   = indexReg;
  end

  // R1: the index only moves on a write to offset 0
  p_index_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && !busAddr) |=> $stable(indexReg));

  // R7: pin registers are never decoded outside the GPIO bank
  p_bank_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !gpioBankSel |-> !(strobes.kind inside {KIND_PINSEL, KIND_PINCFG, KIND_PINEVT}));

endmodule

// File: rtl/cfg_space_dpath.sv
module cfg_space_dpath
  import cfg_space_pkg::*;
#(
  parameter int         NUM_DEV  = 15,
  parameter int         NUM_PINS = 29,
  parameter int         GPIO_DEV = 7,
  parameter logic [7:0] CHIP_ID  = 8'hE9,
  parameter logic [7:0] REV_ID   = 8'h01
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfgStrobe_t              strobes,
  input  logic [7:0]              busWdata,
  output logic                    gpioBankSel,
  output logic [7:0]              rdData,
  output logic [NUM_DEV-1:0]      devEnable,
  output logic [NUM_DEV*16-1:0]   devBase,
  output logic [NUM_PINS-1:0]     pinOutEn,
  output logic [NUM_PINS-1:0]     pinPushPull,
  output logic [NUM_PINS-1:0]     pinPullUp,
  output logic [NUM_PINS*2-1:0]   pinEvtCfg
);

  localparam int DEV_W      = $clog2(NUM_DEV);
  localparam int PIN_W      = $clog2(NUM_PINS);
  localparam int PORT_COUNT = (NUM_PINS + 7) / 8;

  logic [DEV_W-1:0]              devSel;
  logic [NUM_DEV-1:0][15:0]      baseArr;
  logic [7:0]                    pinSelReg;
  logic [6:0]                    pinFlat;
  logic                          pinValid;
  logic [PIN_W-1:0]              pinIdx;
  logic [7:0]                    rdVal;
  logic                          wrDevSel, wrEnable, wrBaseHi, wrBaseLo;
  logic                          wrPinSel, wrPinCfg, wrPinEvt;

  assign wrDevSel = strobes.wrData && strobes.kind == KIND_DEVSEL;
  assign wrEnable = strobes.wrData && strobes.kind == KIND_ENABLE;
  assign wrBaseHi = strobes.wrData && strobes.kind == KIND_BASEHI;
  assign wrBaseLo = strobes.wrData && strobes.kind == KIND_BASELO;
  assign wrPinSel = strobes.wrData && strobes.kind == KIND_PINSEL;
  assign wrPinCfg = strobes.wrData && strobes.kind == KIND_PINCFG && pinValid;
  assign wrPinEvt = strobes.wrData && strobes.kind == KIND_PINEVT && pinValid;

  assign gpioBankSel = (32'(devSel) == GPIO_DEV);
  assign devBase     = baseArr;

  // device selector, out-of-range values rejected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) devSel <= '0;
    else if (wrDevSel && 32'(busWdata) < NUM_DEV) devSel <= busWdata[DEV_W-1:0];
  end

  // per-device bank registers
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = (32'(devSel) == d);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        devEnable[d] <= 1'b0;
        baseArr[d]   <= 16'h0000;
      end else if (hit) begin
        if (wrEnable) devEnable[d]     <= busWdata[0];
        if (wrBaseHi) baseArr[d][15:8] <= busWdata;
        if (wrBaseLo) baseArr[d][7:0]  <= busWdata;
      end
    end
  end

  // pin selector and its decode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSelReg <= 8'h00;
    else if (wrPinSel) pinSelReg <= busWdata & 8'hF7;
  end

  assign pinFlat  = {pinSelReg[7:4], pinSelReg[2:0]};
  assign pinValid = (32'(pinSelReg[7:4]) < PORT_COUNT) && (32'(pinFlat) < NUM_PINS);
  assign pinIdx   = pinFlat[PIN_W-1:0];

  // per-pin configuration
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = (32'(pinIdx) == p);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinOutEn[p]        <= 1'b0;
        pinPushPull[p]     <= 1'b0;
        pinPullUp[p]       <= 1'b0;
        pinEvtCfg[2*p +: 2] <= 2'b00;
      end else if (hit) begin
        if (wrPinCfg) begin
          pinOutEn[p]    <= busWdata[0];
          pinPushPull[p] <= busWdata[1];
          pinPullUp[p]   <= busWdata[2];
        end
        if (wrPinEvt) pinEvtCfg[2*p +: 2] <= busWdata[1:0];
      end
    end
  end

  // read multiplexer
  always_comb begin
    rdVal = 8'h00;
    case (strobes.kind)
      KIND_CHIPID: rdVal = CHIP_ID;
      KIND_REV:    rdVal = REV_ID;
      KIND_DEVSEL: rdVal = 8'(devSel);
      KIND_ENABLE: rdVal = {7'b0, devEnable[devSel]};
      KIND_BASEHI: rdVal = baseArr[devSel][15:8];
      KIND_BASELO: rdVal = baseArr[devSel][7:0];
      KIND_PINSEL: rdVal = pinSelReg;
      KIND_PINCFG: rdVal = pinValid ? {5'b0, pinPullUp[pinIdx], pinPushPull[pinIdx], pinOutEn[pinIdx]} : 8'h00;
      KIND_PINEVT: rdVal = pinValid ? {6'b0, pinEvtCfg[2*pinIdx +: 2]} : 8'h00;
      default:     rdVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= 8'h00;
    else if (strobes.rdIndex) rdData <= strobes.index;
    else if (strobes.rdData) rdData <= rdVal;
  end

  // R2: chip identifier comes back on the following cycle
  p_chip_id_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdData && strobes.kind == KIND_CHIPID) |=> rdData == CHIP_ID);

  // R3: selector never leaves the device range
  p_devsel_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    32'(devSel) < NUM_DEV);

  // R4/R6: enable flags move only on an enable write
  p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrData && strobes.kind == KIND_ENABLE) |=> $stable(devEnable));

  // R5: base addresses move only on a base write
  p_base_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrData && strobes.kind inside {KIND_BASEHI, KIND_BASELO}) |=> $stable(devBase));

  // R10: invalid pin selection leaves every pin untouched
  p_pin_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrData && !pinValid) |=> ($stable(pinOutEn) && $stable(pinPushPull)
                                       && $stable(pinPullUp) && $stable(pinEvtCfg)));

  // R1: rdData only changes after a read strobe
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.rdData || strobes.rdIndex) |=> $stable(rdData));

endmodule

// File: rtl/cfg_space_top.sv
module cfg_space_top
  import cfg_space_pkg::*;
#(
  parameter int         NUM_DEV  = 15,
  parameter int         NUM_PINS = 29,
  parameter int         GPIO_DEV = 7,
  parameter logic [7:0] CHIP_ID  = 8'hE9,
  parameter logic [7:0] REV_ID   = 8'h01
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [7:0]            busWdata,
  output logic [7:0]            rdData,
  output logic [NUM_DEV-1:0]    devEnable,
  output logic [NUM_DEV*16-1:0] devBase,
  output logic [NUM_PINS-1:0]   pinOutEn,
  output logic [NUM_PINS-1:0]   pinPushPull,
  output logic [NUM_PINS-1:0]   pinPullUp,
  output logic [NUM_PINS*2-1:0] pinEvtCfg
);

  cfgStrobe_t strobes;
  logic       gpioBankSel;

  cfg_space_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busRd      (busRd),
    .busWdata   (busWdata),
    .gpioBankSel(gpioBankSel),
    .strobes    (strobes)
  );

  cfg_space_dpath #(
    .NUM_DEV (NUM_DEV),
    .NUM_PINS(NUM_PINS),
    .GPIO_DEV(GPIO_DEV),
    .CHIP_ID (CHIP_ID),
    .REV_ID  (REV_ID)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busWdata   (busWdata),
    .gpioBankSel(gpioBankSel),
    .rdData     (rdData),
    .devEnable  (devEnable),
    .devBase    (devBase),
    .pinOutEn   (pinOutEn),
    .pinPushPull(pinPushPull),
    .pinPullUp  (pinPullUp),
    .pinEvtCfg  (pinEvtCfg)
  );

endmodule

// File: tb/cfg_space_top_bench.sv
`timescale 1ns/1ps
module cfg_space_top_bench;

  typedef struct packed {
    logic       isRd;
    logic       addr;
    logic [7:0] data;
    logic [7:0] expv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,8'h20,8'h00,4'd0},  '{1'b1,1'b1,8'h00,8'hE9,4'd2},   // R2 id
    '{1'b0,1'b1,8'h55,8'h00,4'd0},  '{1'b1,1'b1,8'h00,8'hE9,4'd2},   // R2 write ignored
    '{1'b0,1'b0,8'h27,8'h00,4'd0},  '{1'b1,1'b1,8'h00,8'h01,4'd2},   // R2 revision
    '{1'b1,1'b0,8'h00,8'h27,4'd1},                                   // R1 index readback
    '{1'b0,1'b0,8'h07,8'h00,4'd0},  '{1'b0,1'b1,8'h03,8'h00,4'd0},
    '{1'b1,1'b1,8'h00,8'h03,4'd3},                                   // R3
    '{1'b0,1'b1,8'h0F,8'h00,4'd0},  '{1'b1,1'b1,8'h00,8'h03,4'd3},   // R3 out of range
    '{1'b0,1'b0,8'h30,8'h00,4'd0},  '{1'b0,1'b1,8'hFF,8'h00,4'd0},
    '{1'b1,1'b1,8'h00,8'h01,4'd4},                                   // R4
    '{1'b0,1'b0,8'h60,8'h00,4'd0},  '{1'b0,1'b1,8'h12,8'h00,4'd0},
    '{1'b0,1'b0,8'h61,8'h00,4'd0},  '{1'b0,1'b1,8'h34,8'h00,4'd0},
    '{1'b1,1'b1,8'h00,8'h34,4'd5},                                   // R5 low
    '{1'b0,1'b0,8'h60,8'h00,4'd0},  '{1'b1,1'b1,8'h00,8'h12,4'd5},   // R5 high
    '{1'b0,1'b0,8'h07,8'h00,4'd0},  '{1'b0,1'b1,8'h05,8'h00,4'd0},
    '{1'b0,1'b0,8'h30,8'h00,4'd0},  '{1'b1,1'b1,8'h00,8'h00,4'd6},   // R6 other bank
    '{1'b0,1'b0,8'h60,8'h00,4'd0},  '{1'b1,1'b1,8'h00,8'h00,4'd6},
    '{1'b0,1'b0,8'hF0,8'h00,4'd0},  '{1'b0,1'b1,8'h0F,8'h00,4'd0},
    '{1'b1,1'b1,8'h00,8'h00,4'd7},                                   // R7 hidden
    '{1'b0,1'b0,8'h07,8'h00,4'd0},  '{1'b0,1'b1,8'h07,8'h00,4'd0},
    '{1'b0,1'b0,8'hF0,8'h00,4'd0},  '{1'b0,1'b1,8'h1B,8'h00,4'd0},
    '{1'b1,1'b1,8'h00,8'h13,4'd7},                                   // R7 bit 3 dropped
    '{1'b0,1'b0,8'hF1,8'h00,4'd0},  '{1'b0,1'b1,8'hFF,8'h00,4'd0},
    '{1'b1,1'b1,8'h00,8'h07,4'd8},                                   // R8
    '{1'b0,1'b0,8'hF2,8'h00,4'd0},  '{1'b0,1'b1,8'h03,8'h00,4'd0},
    '{1'b1,1'b1,8'h00,8'h03,4'd9},                                   // R9
    '{1'b0,1'b0,8'hF0,8'h00,4'd0},  '{1'b0,1'b1,8'h35,8'h00,4'd0},
    '{1'b0,1'b0,8'hF1,8'h00,4'd0},  '{1'b0,1'b1,8'h07,8'h00,4'd0},
    '{1'b1,1'b1,8'h00,8'h00,4'd10},                                  // R10 pin 29
    '{1'b0,1'b0,8'hF2,8'h00,4'd0},  '{1'b1,1'b1,8'h00,8'h00,4'd10},
    '{1'b0,1'b0,8'h55,8'h00,4'd0},  '{1'b0,1'b1,8'hAA,8'h00,4'd0},
    '{1'b1,1'b1,8'h00,8'h00,4'd11}                                   // R11
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0]   busWdata = 8'h00;
  logic [7:0]   rdData;
  logic [14:0]  devEnable;
  logic [239:0] devBase;
  logic [28:0]  pinOutEn, pinPushPull, pinPullUp;
  logic [57:0]  pinEvtCfg;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  cfg_space_top u_cfg_space_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .rdData(rdData), .devEnable(devEnable), .devBase(devBase),
    .pinOutEn(pinOutEn), .pinPushPull(pinPushPull), .pinPullUp(pinPullUp),
    .pinEvtCfg(pinEvtCfg)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = rdData;
  endtask

  task automatic checkCleared(input string tag);
    check({tag, " rdData"}, 256'(rdData), 256'h0);
    check({tag, " devEnable"}, 256'(devEnable), 256'h0);
    check({tag, " devBase"}, 256'(devBase), 256'h0);
    check({tag, " pin drive"}, 256'({pinOutEn, pinPushPull, pinPullUp}), 256'h0);
    check({tag, " pin events"}, 256'(pinEvtCfg), 256'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkCleared("R12 reset");
    rstN = 1'b1;
    begin
      logic [7:0] got;
      busWrite(1'b0, 8'h07);
      busRead(1'b1, got);
      check("R12 devsel after reset", 256'(got), 256'h0);
    end

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd) begin
        logic [7:0] got;
        busRead(VECS[i].addr, got);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), 256'(got), 256'(VECS[i].expv));
      end else begin
        busWrite(VECS[i].addr, VECS[i].data);
      end
    end

    // R4, R6: only device 3 enabled; R5: its base reached the output
    check("R4 devEnable", 256'(devEnable), 256'(15'h0008));
    check("R5 devBase dev3", 256'(devBase[3*16 +: 16]), 256'h1234);
    check("R6 devBase dev5", 256'(devBase[5*16 +: 16]), 256'h0);
    // R8 pin 11 drive bits, R9 its event bits
    check("R8 pinOutEn", 256'(pinOutEn), 256'(29'd1 << 11));
    check("R8 pinPushPull", 256'(pinPushPull), 256'(29'd1 << 11));
    check("R8 pinPullUp", 256'(pinPullUp), 256'(29'd1 << 11));
    check("R9 pinEvtCfg", 256'(pinEvtCfg), 256'(58'd3 << 22));

    // R10 boundary: pin 28 (port 3, bit 4) is valid
    begin
      logic [7:0] got;
      busWrite(1'b0, 8'hF0); busWrite(1'b1, 8'h34);
      busWrite(1'b0, 8'hF1); busWrite(1'b1, 8'h05);
      busRead(1'b1, got);
      check("R10 pin 28 readback", 256'(got), 256'h05);
      check("R10 pin 28 outEn", 256'(pinOutEn), 256'((29'd1 << 11) | (29'd1 << 28)));
      check("R10 pin 28 pullUp", 256'(pinPullUp), 256'((29'd1 << 11) | (29'd1 << 28)));
      check("R10 pin 28 pushPull", 256'(pinPushPull), 256'(29'd1 << 11));
      busRead(1'b0, got);
      check("R1 index readback", 256'(got), 256'hF1);
    end

    // R12: reset in mid-run clears everything again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    checkCleared("R12 mid reset");
    rstN = 1'b1;
    begin
      logic [7:0] got;
      busRead(1'b0, got);
      check("R12 index after reset", 256'(got), 256'h0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule